// File: doc/BRIEF.md
# PWM Current-Sense Sample/Hold Trigger

This block decides when an ADC sample/hold stage should hold. It does not generate the PWM signals. It watches the live levels of three complementary PWM output pairs, one high-side and one low-side signal per channel, and evaluates a programmable sum of products over them. There are four product terms:

- all used high-side signals active,
- all used high-side signals inactive,
- all used low-side signals active,
- all used low-side signals inactive.

Each term has its own enable. The enabled terms are ORed together. A polarity bit can then invert the result.

Per-channel use bits remove a channel from the equation. A removed channel reads as TRUE in every product. These bits act only on the trigger logic and never on the PWM signals themselves.

The block registers the result on the system clock as the hold output. It also emits a single-cycle ADC trigger pulse each time the hold output rises. Software sets up the behaviour through a single 8-bit control byte on a small write/read register port.

Top module: `cs_hold_trig`

## Requirements
- R1: After reset the control byte reads 0x00, and `hold` and `adc_trig` are 0.
- R2: When `reg_wr` is high at a clock edge, `reg_wdata` is stored at that edge. `reg_rdata` returns the stored byte unchanged from then on. With `reg_wr` low, the stored byte does not change.
- R3: The control byte fields are: bit 7 polarity, bit 6 high-active enable, bit 5 high-inactive enable, bit 4 low-active enable, bit 3 low-inactive enable. Bits 2, 1 and 0 are the use bits for channels 2, 1 and 0.
- R4: When the high-active enable is 1, a term that is TRUE when every used `pwm_hi` bit is 1 joins the equation. A level of 1 means active.
- R5: When the high-inactive enable is 1, a term that is TRUE when every used `pwm_hi` bit is 0 joins the equation.
- R6: When the low-active enable is 1, a term that is TRUE when every used `pwm_lo` bit is 1 joins the equation.
- R7: When the low-inactive enable is 1, a term that is TRUE when every used `pwm_lo` bit is 0 joins the equation.
- R8: When a channel's use bit is 0, that channel counts as TRUE in all four terms, whatever its levels.
- R9: The raw condition is the OR of the enabled terms. With no enable set it is FALSE.
- R10: At each clock edge `hold` takes the value (polarity XOR raw condition), computed from the inputs and the control byte present before that edge.
- R11: `adc_trig` is high for exactly the one cycle in which `hold` has just changed from 0 to 1, and is low at all other times.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Control byte write strobe |
| reg_wdata | input | 8 | Control byte write data |
| reg_rdata | output | 8 | Stored control byte |
| pwm_hi | input | 3 | High-side PWM levels, channels 2..0 |
| pwm_lo | input | 3 | Low-side PWM levels, channels 2..0 |
| hold | output | 1 | Registered sample/hold command |
| adc_trig | output | 1 | One-cycle pulse on each rising edge of hold |

## Verification
The hardest cases to reach are those where a masked channel forces a term TRUE, with the inactive terms and the polarity inversion layered on top. A single wrong factor shows up only for a few of the 64 level patterns under a few of the 256 control values. The bench therefore writes every control byte and, under each one, sweeps all 64 combinations of high-side and low-side levels. This covers each masking, enable and polarity combination against every input pattern. Writes are interleaved with the sweep, so the one-cycle lag of a new setting and the trigger pulses that arise around configuration changes are both checked.

// File: rtl/cs_hold_pkg.sv
package cs_hold_pkg;
  localparam int CS_NCH   = 3;
  localparam int CS_REG_W = 8;

  // Control byte layout, most significant field first
  typedef struct packed {
    logic              inv;
    logic              hi_on_en;
    logic              hi_off_en;
    logic              lo_on_en;
    logic              lo_off_en;
    logic [CS_NCH-1:0] ch_use;
  } cs_cfg_t;

  // Product over the used channels; an unused channel contributes TRUE
  function automatic logic cs_all_used(input logic [CS_NCH-1:0] lvl,
                                       input logic [CS_NCH-1:0] use_m);
    return &(lvl | ~use_m);
  endfunction
endpackage

// File: rtl/cs_cfg_reg.sv
module cs_cfg_reg
  import cs_hold_pkg::*;
#(
  parameter int W = CS_REG_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] rdata,
  output cs_cfg_t      cfg
);
  logic [W-1:0] cfg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  cfg_q <= '0;
    else if (wr) cfg_q <= wdata;
  end

  assign rdata = cfg_q;
  assign cfg   = cs_cfg_t'(cfg_q);

  // R2
  wr_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr |=> rdata == $past(wdata));
  // R2
  idle_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr |=> $stable(rdata));
endmodule

// File: rtl/cs_term_eval.sv
module cs_term_eval
  import cs_hold_pkg::*;
#(
  parameter int NCH = CS_NCH
) (
  input  logic           clk,
  input  logic           rst_n,
  input  cs_cfg_t        cfg,
  input  logic [NCH-1:0] pwm_hi,
  input  logic [NCH-1:0] pwm_lo,
  output logic [3:0]     terms,
  output logic           raw
);
  localparam int NTERM = 4;

  logic [NCH-1:0] hi_on_f, hi_off_f, lo_on_f, lo_off_f;
  logic [NTERM-1:0] prod, en;

  // One factor per channel and per sense; an unused channel is TRUE
  for (genvar i = 0; i < NCH; i++) begin : g_ch
    assign hi_on_f[i]  = ~cfg.ch_use[i] |  pwm_hi[i];
    assign hi_off_f[i] = ~cfg.ch_use[i] | ~pwm_hi[i];
    assign lo_on_f[i]  = ~cfg.ch_use[i] |  pwm_lo[i];
    assign lo_off_f[i] = ~cfg.ch_use[i] | ~pwm_lo[i];
  end

  assign prod  = {&hi_on_f, &hi_off_f, &lo_on_f, &lo_off_f};
  assign en    = {cfg.hi_on_en, cfg.hi_off_en, cfg.lo_on_en, cfg.lo_off_en};
  assign terms = prod & en;
  assign raw   = |terms;

  // R4
  hi_on_term_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg.hi_on_en && cs_all_used(pwm_hi, cfg.ch_use)) |-> raw);
  // R7
  lo_off_term_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg.lo_off_en && cs_all_used(~pwm_lo, cfg.ch_use)) |-> raw);
  // R8
  all_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg.ch_use == '0 && en != '0) |-> raw);
  // R9
  no_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en == '0) |-> !raw);
endmodule

// File: rtl/cs_hold_out.sv
module cs_hold_out (
  input  logic clk,
  input  logic rst_n,
  input  logic inv,
  input  logic raw,
  output logic hold,
  output logic trig
);
  logic hold_d, hold_q, prev_q;

  assign hold_d = inv ^ raw;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= 1'b0;
      prev_q <= 1'b0;
    end else begin
      hold_q <= hold_d;
      prev_q <= hold_q;
    end
  end

  assign hold = hold_q;
  assign trig = hold_q & ~prev_q;

  // R11
  trig_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trig |=> !trig);
  // R11
  trig_needs_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trig |-> hold);
  // R11
  rise_gives_trig_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hold) |-> trig);
endmodule

// File: rtl/cs_hold_trig.sv
module cs_hold_trig
  import cs_hold_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                reg_wr,
  input  logic [CS_REG_W-1:0] reg_wdata,
  output logic [CS_REG_W-1:0] reg_rdata,
  input  logic [CS_NCH-1:0]   pwm_hi,
  input  logic [CS_NCH-1:0]   pwm_lo,
  output logic                hold,
  output logic                adc_trig
);
  cs_cfg_t    cfg;
  logic [3:0] terms;
  logic       raw;

  cs_cfg_reg #(.W(CS_REG_W)) u_reg (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .wdata(reg_wdata),
    .rdata(reg_rdata), .cfg(cfg)
  );

  cs_term_eval #(.NCH(CS_NCH)) u_eval (
    .clk(clk), .rst_n(rst_n), .cfg(cfg), .pwm_hi(pwm_hi), .pwm_lo(pwm_lo),
    .terms(terms), .raw(raw)
  );

  cs_hold_out u_out (
    .clk(clk), .rst_n(rst_n), .inv(cfg.inv), .raw(raw),
    .hold(hold), .trig(adc_trig)
  );

  // R10
  hold_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (terms == '0 && $stable(cfg) && $stable(terms)) |=> hold == $past(cfg.inv));
endmodule

// File: tb/tb_cs_hold_trig.sv
`timescale 1ns/1ps
module tb_cs_hold_trig;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_wr = 1'b0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic [2:0] pwm_hi = 3'b000;
  logic [2:0] pwm_lo = 3'b000;
  logic       hold, adc_trig;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;
  logic [7:0] m_cfg;
  logic       m_prev;

  always #10 clk = ~clk;

  cs_hold_trig dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .pwm_hi(pwm_hi), .pwm_lo(pwm_lo),
    .hold(hold), .adc_trig(adc_trig)
  );

  // Bench model: counts the channels that satisfy each term
  function automatic logic model(input logic [7:0] c, input logic [2:0] h,
                                 input logic [2:0] l);
    int hon = 0, hoff = 0, lon = 0, loff = 0, used = 0;
    logic r;
    for (int i = 0; i < 3; i++) begin
      if (c[i]) begin
        used++;
        if (h[i]) hon++; else hoff++;
        if (l[i]) lon++; else loff++;
      end
    end
    r = (c[6] && hon == used) || (c[5] && hoff == used) ||
        (c[4] && lon == used) || (c[3] && loff == used);
    return r ^ c[7];
  endfunction

  function automatic string tag(input logic [7:0] c);
    if (c[6:3] == 4'b0)   return "R9";
    if (c[2:0] != 3'b111) return "R8";
    if (c[6])             return c[7] ? "R10" : "R4";
    if (c[5])             return "R5";
    if (c[4])             return "R6";
    return "R7";
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h (cfg %02h hi %b lo %b)",
               req, act, exp, m_cfg, pwm_hi, pwm_lo);
    end
  endtask

  task automatic tick();
    logic e;
    @(posedge clk);
    e = model(m_cfg, pwm_hi, pwm_lo);
    if (reg_wr) m_cfg = reg_wdata;
    @(negedge clk);
    chk(tag(m_cfg), {7'b0, hold}, {7'b0, e});            // R10
    chk("R11", {7'b0, adc_trig}, {7'b0, e & ~m_prev});   // R11
    chk("R2", reg_rdata, m_cfg);                         // R2
    m_prev = e;
  endtask

  task automatic wr_cfg(input logic [7:0] v);
    reg_wr = 1'b1; reg_wdata = v;
    tick();
    reg_wr = 1'b0; reg_wdata = ~v;
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    m_cfg = 8'h00; m_prev = 1'b0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1", reg_rdata, 8'h00);
    chk("R1", {7'b0, hold}, 8'h00);
    chk("R1", {7'b0, adc_trig}, 8'h00);
    rst_n = 1'b1;
    tick();
    // R3: polarity alone in bit 7 drives hold high, and a trigger follows
    wr_cfg(8'h80);
    pwm_hi = 3'b101; pwm_lo = 3'b010;
    tick();
    chk("R3", {7'b0, hold}, 8'h01);
    // R3: bit 6 with all channels used, all high sides active
    wr_cfg(8'h47);
    pwm_hi = 3'b111;
    tick();
    chk("R3", {7'b0, hold}, 8'h01);
    pwm_hi = 3'b110;
    tick();
    chk("R3", {7'b0, hold}, 8'h00);
    // R2: a byte with no write strobe leaves the register untouched
    reg_wdata = 8'hFF;
    tick();
    chk("R2", reg_rdata, 8'h47);
    // Full sweep: every control byte against every level pattern (R4 R5 R6 R7 R8 R9 R10 R11)
    for (int c = 0; c < 256; c++) begin
      wr_cfg(c[7:0]);
      for (int p = 0; p < 64; p++) begin
        pwm_hi = p[2:0];
        pwm_lo = p[5:3];
        tick();
      end
    end
    summary();
  end
endmodule